// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Front End

This block puts a simple asynchronous serial port behind a 32-bit register bus. Software sends a byte by writing it to the transmit data word, takes a received byte by reading the receive data word, and polls a status word with two flags: one says a received byte is waiting, the other says the transmitter can take a new byte. Line framing is one start bit, eight data bits least significant first and one stop bit. The bit period is a fixed number of clock cycles set by a parameter.

The receive side keeps exactly one byte. It never overwrites a byte that software has not yet taken. A frame that completes while the holding word is full stays in the deserializer until the read happens, and the port does not look at the line again until then. No flag reports this stall. Status writes, partial-word accesses and accesses to unused words do nothing.

Register words, as byte addresses: transmit data 0x00, receive data 0x04, status 0x14. The decoded window is six words (0x00 to 0x17). The word index is the byte address shifted right by two. The two lowest address bits are ignored.

Top module: `uart_regfront`

## Requirements
- R1: After reset, status reads 0x0000_0002, receive data reads 0x0000_0000 and the serial output is high.
- R2: Status bit 0 is receive-ready and status bit 1 is transmit-ready. Bits 31 to 2 always read zero.
- R3: A full-word read of receive data (0x04) returns the held byte in bits 7 to 0, with zeros above. The same read clears receive-ready.
- R4: A frame that completes while receive-ready is set does not change the held byte. After software reads the held byte, the waiting frame is stored and receive-ready sets again.
- R5: A frame with a low start bit at mid-bit and a high stop bit at mid-bit is stored. Receive-ready then sets before the stop bit has ended.
- R6: A frame whose stop bit samples low is dropped. Receive-ready and the held byte are left unchanged.
- R7: Writes to status (0x14) change no state.
- R8: An access whose byte enables are not all four set is ignored. A read returns zero. A write starts no transmission. A read of receive data does not clear receive-ready.
- R9: Reads of unused words (0x08, 0x0C, 0x10) and of words outside the window (0x18 and above) return zero. Writes to them change no state.
- R10: A full-word write to transmit data (0x00) while transmit-ready is set sends bits 7 to 0 of the written word on the serial output: a low start bit, the data least significant bit first, then a high stop bit. Each bit lasts CLKS_PER_BIT cycles, and the start bit begins the cycle after the write.
- R11: Transmit-ready reads 0 from the cycle after the write until the stop bit has ended. A transmit write made while it is 0 is discarded. The serial output is high whenever transmit-ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is honoured |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the request |
| rxd | input | 1 | Serial receive line (asynchronous, idle high) |
| txd | output | 1 | Serial transmit line (idle high) |

## Verification
The bench sends two frames back to back without reading in between. A design that overwrote the held byte would return the second byte first. A design that dropped the waiting frame would never set receive-ready again after the read. A frame with a low stop bit must leave the port as it was. A receiver that skipped the stop check would report a spurious byte. A transmit write made while busy, with a byte of all ones in flight, exposes any reload of the shifter, because reloaded zero bits would appear mid-frame. Partial-enable accesses, status writes and unused offsets are each followed by status and line checks, so a decoder that ignores the byte enables or aliases those offsets would clear a flag or start a frame.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned BYTE_W  = 8;

    // word indices (byte address >> 2)
    localparam int unsigned IDX_TXD   = 0;
    localparam int unsigned IDX_RXD   = 1;
    localparam int unsigned IDX_STAT  = 5;
    localparam int unsigned WIN_WORDS = 6;

    localparam int unsigned STAT_RX_BIT = 0;
    localparam int unsigned STAT_TX_BIT = 1;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_TXD,
        REG_RXD,
        REG_STAT
    } reg_sel_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        reg_sel_e           sel;
        logic               rd_rx;
        logic               wr_tx;
        logic [BYTE_W-1:0]  wbyte;
    } bus_cmd_t;

    function automatic reg_sel_e decode_idx(input int unsigned idx);
        if (idx >= WIN_WORDS) return REG_NONE;
        case (idx)
            IDX_TXD:  return REG_TXD;
            IDX_RXD:  return REG_RXD;
            IDX_STAT: return REG_STAT;
            default:  return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/uart_bus_decode.sv
module uart_bus_decode
    import uart_regfront_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [WORD_W-1:0] wdata,
    output bus_cmd_t          cmd
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             full_word;
    reg_sel_e         sel;

    assign idx       = addr[ADDR_W-1:2];
    assign full_word = (be == 4'hF);

    always_comb begin
        sel = REG_NONE;
        if (valid && full_word)
            sel = decode_idx(int'(idx));
        cmd.sel   = sel;
        cmd.rd_rx = (sel == REG_RXD) && !write;
        cmd.wr_tx = (sel == REG_TXD) && write;
        cmd.wbyte = wdata[BYTE_W-1:0];
    end

endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
    import uart_regfront_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] data,
    output logic              txd,
    output logic              busy
);
    localparam int unsigned CNT_W   = $clog2(CLKS_PER_BIT);
    localparam int unsigned FRAME_B = BYTE_W + 2;
    localparam int unsigned BIT_W   = $clog2(FRAME_B);

    logic [FRAME_B-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   nbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            cnt   <= '0;
            nbit  <= '0;
            busy  <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                shreg <= {1'b1, data, 1'b0};
                cnt   <= '0;
                nbit  <= '0;
                busy  <= 1'b1;
            end
        end else if (cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
            cnt   <= '0;
            shreg <= {1'b1, shreg[FRAME_B-1:1]};
            if (nbit == BIT_W'(FRAME_B - 1))
                busy <= 1'b0;
            else
                nbit <= nbit + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign txd = busy ? shreg[0] : 1'b1;

endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_regfront_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              take,
    output logic              frame_valid,
    output logic [BYTE_W-1:0] frame_byte
);
    localparam int unsigned CNT_W = $clog2(CLKS_PER_BIT);
    localparam int unsigned HALF  = CLKS_PER_BIT / 2;
    localparam int unsigned BIT_W = $clog2(BYTE_W);

    rx_state_e         st;
    logic [1:0]        sync;
    logic              prev;
    logic              rx_s;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  nbit;
    logic [BYTE_W-1:0] shreg;

    assign rx_s = sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= 2'b11;
            prev  <= 1'b1;
            st    <= RX_IDLE;
            cnt   <= '0;
            nbit  <= '0;
            shreg <= '0;
        end else begin
            sync <= {sync[0], rxd};
            prev <= rx_s;
            case (st)
                RX_IDLE: begin
                    if (prev && !rx_s) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == CNT_W'(HALF - 1)) begin
                        cnt  <= '0;
                        nbit <= '0;
                        st   <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
                        cnt   <= '0;
                        shreg <= {rx_s, shreg[BYTE_W-1:1]};
                        if (nbit == BIT_W'(BYTE_W - 1))
                            st <= RX_STOP;
                        else
                            nbit <= nbit + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
                        cnt <= '0;
                        st  <= rx_s ? RX_HOLD : RX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (take) st <= RX_IDLE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    assign frame_valid = (st == RX_HOLD);
    assign frame_byte  = shreg;

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  logic [BYTE_W-1:0] frame_byte,
    input  logic              rd_clear,
    output logic              take,
    output logic              ready,
    output logic [BYTE_W-1:0] held
);
    assign take = frame_valid && !ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
            held  <= '0;
        end else if (take) begin
            ready <= 1'b1;
            held  <= frame_byte;
        end else if (rd_clear) begin
            ready <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int unsigned ADDR_W       = 5,
    parameter int unsigned CLKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rxd,
    output logic              txd
);
    bus_cmd_t          cmd;
    logic              tx_busy;
    logic              tx_ready;
    logic              rx_ready;
    logic [BYTE_W-1:0] rx_byte;
    logic              frame_valid;
    logic [BYTE_W-1:0] frame_byte;
    logic              take;

    uart_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .be    (bus_be),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    uart_tx_ser #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .start (cmd.wr_tx),
        .data  (cmd.wbyte),
        .txd   (txd),
        .busy  (tx_busy)
    );

    assign tx_ready = !tx_busy;

    uart_rx_deser #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .rxd         (rxd),
        .take        (take),
        .frame_valid (frame_valid),
        .frame_byte  (frame_byte)
    );

    uart_rx_hold u_hold (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid),
        .frame_byte  (frame_byte),
        .rd_clear    (cmd.rd_rx),
        .take        (take),
        .ready       (rx_ready),
        .held        (rx_byte)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_write) begin
            case (cmd.sel)
                REG_RXD:  bus_rdata[BYTE_W-1:0] = rx_byte;
                REG_STAT: begin
                    bus_rdata[STAT_RX_BIT] = rx_ready;
                    bus_rdata[STAT_TX_BIT] = tx_ready;
                end
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_rdata,
    input logic              txd,
    input logic              rx_ready,
    input logic              tx_ready,
    input logic [7:0]        rx_byte
);
    logic full_word;
    logic rd_any;
    logic rd_rx;
    logic rd_stat;
    logic wr_stat;

    assign full_word = (bus_be == 4'hF);
    assign rd_any    = bus_valid && !bus_write;
    assign rd_rx     = rd_any && full_word && (bus_addr[ADDR_W-1:2] == 1);
    assign rd_stat   = rd_any && full_word && (bus_addr[ADDR_W-1:2] == 5);
    assign wr_stat   = bus_valid && bus_write && full_word && (bus_addr[ADDR_W-1:2] == 5);

    // R2
    stat_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stat |-> (bus_rdata[31:2] == 30'd0));

    // R3
    rx_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rd_rx |=> !rx_ready);

    // R4
    held_byte_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !rd_rx) |=> $stable(rx_byte));

    // R7
    stat_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && rx_ready) |=> rx_ready);

    // R8
    partial_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_any && !full_word) |-> (bus_rdata == 32'd0));

    // R11
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);

endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .txd       (txd),
    .rx_ready  (rx_ready),
    .tx_ready  (tx_ready),
    .rx_byte   (rx_byte)
);

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned CPB    = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [3:0]        bus_be = 4'h0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              rxd = 1'b1;
    logic              txd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_regfront #(.ADDR_W(ADDR_W), .CLKS_PER_BIT(CPB)) u_uart_regfront (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rxd       (rxd),
        .txd       (txd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_valid = 1'b0;
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] v, input logic [3:0] be);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = v;
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_bit);
        logic [9:0] fr;
        fr = {stop_bit, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rxd = fr[i];
            repeat (CPB - 1) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(5'h14, 4'hF, d); chk("R1 status after reset", d, 32'h2);
        bus_rd(5'h04, 4'hF, d); chk("R1 rx data after reset", d, 32'h0);
        chk("R1 txd idle high", {31'd0, txd}, 32'd1);
    endtask

    task automatic t_tx_frame(input logic [31:0] word);
        logic [9:0] exp;
        exp = {1'b1, word[7:0], 1'b0};
        bus_wr(5'h00, word, 4'hF);
        repeat (CPB / 2) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            chk($sformatf("R10 tx bit %0d", i), {31'd0, txd}, {31'd0, exp[i]});
            if (i < 9) repeat (CPB) @(negedge clk);
        end
        repeat (CPB) @(negedge clk);
    endtask

    task automatic t_tx_busy();
        logic [31:0] d;
        bus_wr(5'h00, 32'h0000_00FF, 4'hF);
        bus_wr(5'h00, 32'h0000_0000, 4'hF);
        bus_rd(5'h14, 4'hF, d); chk("R11 tx-ready low while shifting", d, 32'h0);
        repeat (CPB + CPB / 2 - 2) @(negedge clk);
        for (int i = 1; i < 10; i++) begin
            chk($sformatf("R11 busy write discarded, bit %0d", i), {31'd0, txd}, 32'd1);
            if (i < 9) repeat (CPB) @(negedge clk);
        end
        repeat (CPB) @(negedge clk);
        bus_rd(5'h14, 4'hF, d); chk("R11 tx-ready back after stop", d, 32'h2);
    endtask

    task automatic t_rx_basic();
        logic [31:0] d;
        send_frame(8'h5A, 1'b1);
        bus_rd(5'h14, 4'hF, d); chk("R5 rx-ready after frame", d, 32'h3);
        bus_rd(5'h04, 4'hF, d); chk("R3 rx data", d, 32'h5A);
        bus_rd(5'h14, 4'hF, d); chk("R3 read cleared rx-ready", d, 32'h2);
    endtask

    task automatic t_rx_backpressure();
        logic [31:0] d;
        send_frame(8'h3C, 1'b1);
        send_frame(8'hC3, 1'b1);
        bus_rd(5'h14, 4'hF, d); chk("R4 rx-ready while second waits", d, 32'h3);
        bus_rd(5'h04, 4'hF, d); chk("R4 first byte kept", d, 32'h3C);
        bus_rd(5'h14, 4'hF, d); chk("R3 cleared by read", d, 32'h2);
        repeat (3) @(negedge clk);
        bus_rd(5'h14, 4'hF, d); chk("R4 waiting frame delivered", d, 32'h3);
        bus_rd(5'h04, 4'hF, d); chk("R4 second byte", d, 32'hC3);
    endtask

    task automatic t_rx_bad_stop();
        logic [31:0] d;
        send_frame(8'h55, 1'b0);
        repeat (CPB) @(negedge clk);
        bus_rd(5'h14, 4'hF, d); chk("R6 bad frame leaves rx-ready clear", d, 32'h2);
        bus_rd(5'h04, 4'hF, d); chk("R6 held byte unchanged", d, 32'hC3);
        send_frame(8'h81, 1'b1);
        bus_rd(5'h04, 4'hF, d); chk("R5 good frame after bad", d, 32'h81);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        send_frame(8'hE7, 1'b1);
        bus_wr(5'h14, 32'h0000_0000, 4'hF);
        bus_wr(5'h14, 32'hFFFF_FFFF, 4'hF);
        bus_rd(5'h14, 4'hF, d); chk("R7 status write ignored", d, 32'h3);
        bus_rd(5'h04, 4'h3, d); chk("R8 partial read is zero", d, 32'h0);
        bus_rd(5'h14, 4'hF, d); chk("R8 partial read kept rx-ready", d, 32'h3);
        bus_wr(5'h00, 32'h0000_0000, 4'h1);
        bus_rd(5'h14, 4'hF, d); chk("R8 partial write no tx", d, 32'h3);
        bus_rd(5'h08, 4'hF, d); chk("R9 unused 0x08 reads zero", d, 32'h0);
        bus_rd(5'h0C, 4'hF, d); chk("R9 unused 0x0C reads zero", d, 32'h0);
        bus_rd(5'h10, 4'hF, d); chk("R9 unused 0x10 reads zero", d, 32'h0);
        bus_rd(5'h18, 4'hF, d); chk("R9 outside window reads zero", d, 32'h0);
        bus_wr(5'h08, 32'h0000_0000, 4'hF);
        bus_wr(5'h1C, 32'h0000_0000, 4'hF);
        for (int i = 0; i < CPB; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) chk("R9 R8 line stays idle", {31'd0, txd}, 32'd1);
        end
        bus_rd(5'h14, 4'hF, d); chk("R9 unused writes inert", d, 32'h3);
        bus_rd(5'h04, 4'hF, d); chk("R3 byte after ignored accesses", d, 32'hE7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tx_frame(32'h1234_56A5);
        t_tx_frame(32'hFFFF_FF01);
        t_tx_busy();
        t_rx_basic();
        t_rx_backpressure();
        t_rx_bad_stop();
        t_ignored();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule